// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock for a Split-Register-File FP Pipeline

This block sits in the decode stage of a pipeline that issues instructions in order but lets them finish out of order. The pipeline has separate integer and floating-point register files and several multi-cycle execution units, one of them a divider that is not pipelined. For the instruction waiting in decode, the block receives up to two source operands and one destination. Each operand comes with an enable, a register-file tag and a register index, and the instruction carries a flag that marks it as a divide. The block answers in the same cycle with a stall, an issue strobe and a cause vector.

The block records every destination that has been issued but not yet written back. It keeps one pending bit per register in each file. A bit is set when its instruction issues and is cleared when an execution unit reports completion for that register on one of the completion ports. The block stalls on read-after-write and write-after-write conflicts against those bits. It also stalls a divide while the divider is still busy from an earlier one, and it stalls any register-writing instruction while the write-port-busy input is asserted. Integer register 0 is a constant and is never tracked.

Top module: `fp_decode_interlock`

## Requirements
- R1: After a synchronous active-low reset no register is pending and the divider is free, so a valid instruction with any operands issues (stall 0, issue 1).
- R2: `issue` equals `dec_valid` and not `stall`. An issued instruction with its destination enabled marks that register pending from the next cycle on.
- R3: A valid instruction stalls with cause bit 0 (read hazard) when either enabled source names a pending register in the same file.
- R4: A valid instruction stalls with cause bit 1 (write-order hazard) when its enabled destination names a register that is already pending in the same file.
- R5: The file tag is 0 for integer and 1 for floating point. The same index in the other file never causes a read or write-order hazard.
- R6: An integer destination of index 0 never becomes pending. Reading or writing integer register 0 never stalls on a register hazard.
- R7: A completion on any of the completion ports (valid, file tag, index) clears that register's pending bit at the next edge.
- R8: When a completion clears a register in the same cycle that an issuing instruction sets it, the register ends up pending.
- R9: An issued divide keeps the divider busy for exactly DIV_LAT cycles after its issue edge. During that time a divide stalls with cause bit 2, while other instructions are unaffected.
- R10: While `wport_busy` is high, a valid instruction with its destination enabled stalls with cause bit 3. An instruction without a destination ignores `wport_busy`.
- R11: `stall`, `issue` and `stall_cause` are combinational from the current state and the decode inputs. Several cause bits may be set together.
- R12: With `dec_valid` low, `stall`, `issue` and `stall_cause` are all zero whatever the state, and no pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_src1_en | input | 1 | First source operand is used |
| dec_src1_rf | input | 1 | First source file tag (0 integer, 1 FP) |
| dec_src1_idx | input | IDX_W | First source register index |
| dec_src2_en | input | 1 | Second source operand is used |
| dec_src2_rf | input | 1 | Second source file tag |
| dec_src2_idx | input | IDX_W | Second source register index |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst_rf | input | 1 | Destination file tag |
| dec_dst_idx | input | IDX_W | Destination register index |
| dec_is_div | input | 1 | Instruction uses the divider |
| wport_busy | input | 1 | Register write port reserved this cycle |
| cmp_valid | input | NUM_CMP | Completion notice per port |
| cmp_rf | input | NUM_CMP | Completion file tag per port |
| cmp_idx | input | NUM_CMP*IDX_W | Completion register index per port, port c at bits c*IDX_W upward |
| stall | output | 1 | Decode must hold the instruction |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall_cause | output | 4 | Bit 0 read, bit 1 write-order, bit 2 divider, bit 3 write port |

## Verification
The assertions assume that decode and completion inputs are driven to known values while reset is released. They also assume that a completion reports a register the units actually own, so a clear never races a set on a second completion port. The stimulus keeps to this. Inputs change only at the falling edge. Random traffic draws indices from a small window, so that register collisions, same-cycle set and clear, and cross-file aliasing happen often. Directed sequences cover the whole divider busy window and the write-port input.

// File: rtl/fpdi_pkg.sv
// Shared constants for the decode hazard interlock.
// Assumes: exactly two register files, tagged by one bit.
package fpdi_pkg;
    localparam logic RF_INT     = 1'b0;
    localparam logic RF_FP      = 1'b1;
    localparam int   NUM_FILES  = 2;
    localparam int   CAUSE_W    = 4;
    localparam int   CAUSE_RAW  = 0;
    localparam int   CAUSE_WAW  = 1;
    localparam int   CAUSE_DIV  = 2;
    localparam int   CAUSE_PORT = 3;
endpackage

// File: rtl/fpdi_pend_table.sv
// Pending-destination bit table for one register file.
// Does: one bit per register, set by an issuing writer, cleared by any
// completion port; a set beats a clear of the same register in one cycle.
// Assumes: set_en is already qualified by the caller (file match, not r0).
module fpdi_pend_table #(
    parameter int NUM_REGS = 32,
    parameter int NUM_CMP  = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [IDX_W-1:0]         set_idx,
    input  logic [NUM_CMP-1:0]       clr_en,
    input  logic [NUM_CMP*IDX_W-1:0] clr_idx,
    output logic [NUM_REGS-1:0]      pend
);
    logic [NUM_REGS-1:0] pend_q;
    logic [NUM_REGS-1:0] pend_nxt;

    // Next state: apply all clears, then the set so it takes priority.
    always_comb begin
        pend_nxt = pend_q;
        for (int c = 0; c < NUM_CMP; c++) begin
            if (clr_en[c]) pend_nxt[clr_idx[c*IDX_W +: IDX_W]] = 1'b0;
        end
        if (set_en) pend_nxt[set_idx] = 1'b1;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    assign pend = pend_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend[$past(set_idx)]);                                  // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en[0] && !(set_en && set_idx == clr_idx[0 +: IDX_W]))
        |=> !pend[$past(clr_idx[0 +: IDX_W])]);                            // R7
endmodule

// File: rtl/fpdi_div_track.sv
// Busy tracker for the non-pipelined divider.
// Does: on start, holds busy for DIV_LAT cycles, counted from the start edge.
// Assumes: start is only raised while busy is low.
module fpdi_div_track #(
    parameter int DIV_LAT = 24,
    parameter int CNT_W   = $clog2(DIV_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start)      cnt_q <= CNT_W'(DIV_LAT);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    AST_DIV_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);                                                   // R9
endmodule

// File: rtl/fp_decode_interlock.sv
// Decode-stage hazard interlock for an in-order-issue pipeline.
// Does: combinational stall and issue from pending-destination tables,
// divider busy state and the write-port input; updates state on issue and
// on completion notices.
// Assumes: the instruction in decode holds its fields while stalled.
module fp_decode_interlock
    import fpdi_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_CMP  = 2,
    parameter int DIV_LAT  = 24,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_valid,
    input  logic                     dec_src1_en,
    input  logic                     dec_src1_rf,
    input  logic [IDX_W-1:0]         dec_src1_idx,
    input  logic                     dec_src2_en,
    input  logic                     dec_src2_rf,
    input  logic [IDX_W-1:0]         dec_src2_idx,
    input  logic                     dec_dst_en,
    input  logic                     dec_dst_rf,
    input  logic [IDX_W-1:0]         dec_dst_idx,
    input  logic                     dec_is_div,
    input  logic                     wport_busy,
    input  logic [NUM_CMP-1:0]       cmp_valid,
    input  logic [NUM_CMP-1:0]       cmp_rf,
    input  logic [NUM_CMP*IDX_W-1:0] cmp_idx,
    output logic                     stall,
    output logic                     issue,
    output logic [CAUSE_W-1:0]       stall_cause
);
    logic [NUM_FILES-1:0][NUM_REGS-1:0] pend_vec;
    logic                               div_busy;
    logic                               dst_is_zero;

    assign dst_is_zero = (dec_dst_rf == RF_INT) && (dec_dst_idx == '0);

    // Hazard evaluation for the instruction in decode.
    always_comb begin
        stall_cause = '0;
        if (dec_valid) begin
            stall_cause[CAUSE_RAW]  = (dec_src1_en && pend_vec[dec_src1_rf][dec_src1_idx]) ||
                                      (dec_src2_en && pend_vec[dec_src2_rf][dec_src2_idx]);
            stall_cause[CAUSE_WAW]  = dec_dst_en && pend_vec[dec_dst_rf][dec_dst_idx];
            stall_cause[CAUSE_DIV]  = dec_is_div && div_busy;
            stall_cause[CAUSE_PORT] = dec_dst_en && wport_busy;
        end
    end

    assign stall = |stall_cause;
    assign issue = dec_valid && !stall;

    // One pending table per register file.
    for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
        logic               set_en;
        logic [NUM_CMP-1:0] clr_en;

        assign set_en = issue && dec_dst_en && (dec_dst_rf == 1'(f)) && !dst_is_zero;
        for (genvar c = 0; c < NUM_CMP; c++) begin : g_clr
            assign clr_en[c] = cmp_valid[c] && (cmp_rf[c] == 1'(f));
        end

        fpdi_pend_table #(
            .NUM_REGS (NUM_REGS),
            .NUM_CMP  (NUM_CMP),
            .IDX_W    (IDX_W)
        ) u_tab (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (set_en),
            .set_idx (dec_dst_idx),
            .clr_en  (clr_en),
            .clr_idx (cmp_idx),
            .pend    (pend_vec[f])
        );
    end

    fpdi_div_track #(
        .DIV_LAT (DIV_LAT)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue && dec_is_div),
        .busy  (div_busy)
    );

    AST_WAW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_dst_en) |-> !pend_vec[dec_dst_rf][dec_dst_idx]);     // R4
    AST_RAW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_src1_en) |-> !pend_vec[dec_src1_rf][dec_src1_idx]);  // R3
    AST_DIV_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_is_div) |-> !div_busy);                              // R9
    AST_INT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[RF_INT][0]);                                             // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!stall && !issue));                                // R12
endmodule

// File: tb/tb_fp_decode_interlock.sv
module tb_fp_decode_interlock;
    localparam int NREG  = 32;
    localparam int NCMP  = 2;
    localparam int DLAT  = 24;
    localparam int IW    = $clog2(NREG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid, s1en, s1rf, s2en, s2rf, den, drf, isdiv, wport;
    logic [IW-1:0] s1idx, s2idx, didx;
    logic [NCMP-1:0] cvalid, crf;
    logic [NCMP*IW-1:0] cidx;
    logic stall, issue;
    logic [3:0] cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit m_pend [0:1][0:NREG-1];
    int m_div;

    always #5 clk = ~clk;

    fp_decode_interlock #(.NUM_REGS(NREG), .NUM_CMP(NCMP), .DIV_LAT(DLAT)) dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .dec_src1_en(s1en), .dec_src1_rf(s1rf), .dec_src1_idx(s1idx),
        .dec_src2_en(s2en), .dec_src2_rf(s2rf), .dec_src2_idx(s2idx),
        .dec_dst_en(den), .dec_dst_rf(drf), .dec_dst_idx(didx),
        .dec_is_div(isdiv), .wport_busy(wport),
        .cmp_valid(cvalid), .cmp_rf(crf), .cmp_idx(cidx),
        .stall(stall), .issue(issue), .stall_cause(cause));

    task automatic idle();
        dec_valid = 0; s1en = 0; s1rf = 0; s1idx = 0; s2en = 0; s2rf = 0; s2idx = 0;
        den = 0; drf = 0; didx = 0; isdiv = 0; wport = 0; cvalid = 0; crf = 0; cidx = 0;
    endtask

    task automatic instr(input bit a_en, input bit a_rf, input int a_i,
                         input bit d_en, input bit d_rf, input int d_i, input bit dv);
        dec_valid = 1; s1en = a_en; s1rf = a_rf; s1idx = IW'(a_i);
        s2en = 0; den = d_en; drf = d_rf; didx = IW'(d_i); isdiv = dv;
    endtask

    task automatic comp(input int port, input bit rf, input int idx);
        cvalid[port] = 1'b1; crf[port] = rf; cidx[port*IW +: IW] = IW'(idx);
    endtask

    // Compare against the model, then advance model and clock by one cycle.
    task automatic cycle(input string tag);
        logic [3:0] ec;
        bit es, ei;
        #1;
        ec = 4'b0;
        if (dec_valid) begin
            ec[0] = (s1en && m_pend[s1rf][s1idx]) || (s2en && m_pend[s2rf][s2idx]);
            ec[1] = den && m_pend[drf][didx];
            ec[2] = isdiv && (m_div > 0);
            ec[3] = den && wport;
        end
        es = |ec;
        ei = dec_valid && !es;
        checks++;
        if (stall !== es || issue !== ei || cause !== ec) begin
            errors++;
            $display("FAIL %s: stall/issue/cause actual %b/%b/%b expected %b/%b/%b",
                     tag, stall, issue, cause, es, ei, ec);
        end
        @(posedge clk);
        if (m_div > 0) m_div--;
        for (int c = 0; c < NCMP; c++)
            if (cvalid[c]) m_pend[crf[c]][cidx[c*IW +: IW]] = 0;
        if (ei && den && !(drf == 0 && didx == 0)) m_pend[drf][didx] = 1;
        if (ei && isdiv) m_div = DLAT;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        for (int f = 0; f < 2; f++) for (int r = 0; r < NREG; r++) m_pend[f][r] = 0;
        m_div = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: fresh state lets anything through
        instr(1, 1, 3, 1, 1, 4, 1); s2en = 1; s2rf = 0; s2idx = 7; cycle("R1 reset state");
        // divider now busy from that divide; wait it out with idle cycles
        repeat (DLAT) cycle("R12 idle during div");
        // R2/R3: issue FP5 then read it
        instr(0, 0, 0, 1, 1, 5, 0); cycle("R2 issue FP5");
        instr(1, 1, 5, 0, 0, 0, 0); cycle("R3 read pending FP5");
        s2en = 1; s2rf = 1; s2idx = 5; dec_valid = 1; cycle("R3 second source FP5");
        // R5: integer 5 is a different register
        instr(1, 0, 5, 1, 0, 5, 0); cycle("R5 int5 vs fp5");
        // R4: write FP5 again
        instr(0, 0, 0, 1, 1, 5, 0); cycle("R4 write pending FP5");
        // R11: several causes at once
        instr(1, 1, 5, 1, 1, 5, 0); wport = 1; cycle("R11 combined causes");
        // R12: hazards present but no valid
        s1en = 1; s1rf = 1; s1idx = 5; den = 1; drf = 1; didx = 5; wport = 1; cycle("R12 invalid quiet");
        // R7: clear FP5 on port 1, INT5 on port 0
        comp(1, 1, 5); comp(0, 0, 5); cycle("R7 completion");
        instr(1, 1, 5, 1, 0, 5, 0); cycle("R7 FP5 free again");
        // R8: set and clear FP6 in the same cycle
        instr(0, 0, 0, 1, 1, 6, 0); comp(0, 1, 6); cycle("R8 set with clear");
        instr(1, 1, 6, 0, 0, 0, 0); cycle("R8 FP6 still pending");
        comp(0, 1, 6); cycle("R7 clear FP6");
        // R6: integer register 0
        instr(0, 0, 0, 1, 0, 0, 0); cycle("R6 write int0");
        instr(1, 0, 0, 1, 0, 0, 0); cycle("R6 int0 not pending");
        // R10: write port
        instr(1, 1, 9, 1, 1, 9, 0); wport = 1; cycle("R10 port busy stalls writer");
        instr(1, 1, 9, 0, 0, 0, 0); wport = 1; cycle("R10 non-writer ignores port");
        // R9: divide then divides during busy window, a non-div slips through
        instr(0, 0, 0, 1, 1, 10, 1); cycle("R9 issue divide");
        for (int k = 0; k < DLAT; k++) begin
            if (k == 3) begin instr(0, 0, 0, 1, 1, 12, 0); cycle("R9 non-div during busy"); end
            else begin instr(0, 0, 0, 1, 1, 11, 1); cycle("R9 divide window"); end
        end
        instr(0, 0, 0, 1, 1, 11, 1); cycle("R9 divider released");
        // clean up pending bits
        for (int r = 0; r < NREG; r++) begin comp(0, 1, r); comp(1, 0, r); cycle("R7 drain"); end

        // Random traffic in a small window of registers
        for (int n = 0; n < 3000; n++) begin
            dec_valid = ($urandom_range(0, 9) < 8);
            s1en = $urandom_range(0, 1); s1rf = $urandom_range(0, 1); s1idx = IW'($urandom_range(0, 7));
            s2en = $urandom_range(0, 1); s2rf = $urandom_range(0, 1); s2idx = IW'($urandom_range(0, 7));
            den = $urandom_range(0, 1); drf = $urandom_range(0, 1); didx = IW'($urandom_range(0, 7));
            isdiv = ($urandom_range(0, 9) == 0);
            wport = ($urandom_range(0, 7) == 0);
            for (int c = 0; c < NCMP; c++) if ($urandom_range(0, 9) < 4)
                comp(c, 1'($urandom_range(0, 1)), $urandom_range(0, 7));
            cycle("R2 R3 R4 R8 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule